// File: doc/BRIEF.md
# Display DMA Channel Trigger Controller

This block decides when one DMA channel feeding a display controller may begin each block transfer, and then paces that block as a counted run of element beats. Software programs a 16-bit control word holding enable, repeat, auto-initialize, priority, block-synchronize and a native-mode bit. While native mode is off, the channel runs in a legacy configuration in which repeat, auto-initialize, enable and priority read as 1 whatever was written.

A block starts on enable alone when the channel is software-triggered. It needs enable plus a latched hardware request when the destination is the external display controller and block synchronize is set. Each request starts exactly one block, also in dual-block mode. A request that arrives during a block is held as pending. Further requests before it is used are dropped and raise an overflow flag. Completion gives a one-cycle pulse. In dual-block mode a buffer-select output flips after every finished block. Enable clears itself at completion unless auto-initialize and repeat are both set.

Top module: `dispch_trig`

## Requirements
- R1: Control word bits are: 10 native mode, 9 repeat, 8 auto-initialize, 7 enable, 6 priority, 4 block synchronize. Bits 15:11, 5 and 3:0 read 0. Reset clears all stored bits, so the word reads 0x03C0 after reset. Writing 0xFD3F reads back 0x0510.
- R2: While bit 10 is 0, bits 9:6 read 1 and `prio_hi` is 1. The channel also behaves as enabled, so with software triggering it starts after reset without any write. Writing 0x0000 still reads 0x03C0.
- R3: When `dest_ext`=1 and block synchronize is 1, no block starts without a hardware request. One `hw_req` pulse starts exactly one block.
- R4: In dual-block mode under hardware synchronization, two blocks need two separate requests.
- R5: When `dest_ext`=1 and block synchronize is 0, a block starts on enable with no request.
- R6: When `dest_ext`=0, block synchronize is ignored and a block starts on enable.
- R7: A block is `block_len`+1 accepted beats (`beat_valid` and `beat_ready` both high). `block_done` is high for exactly the one cycle after the last beat is accepted.
- R8: A request during an active block is kept pending and starts the next block. A further request while one is pending sets `req_ovf`. `req_ovf` stays set until a control-word write, which clears it together with any pending request.
- R9: `buf_sel` resets to 0 and flips at each block completion in dual-block mode. In single-block mode it does not change.
- R10: At completion, enable clears unless repeat and auto-initialize are both set. In dual-block mode it clears only at the completion that brings `buf_sel` back to 0.
- R11: If enable drops during a block, the block is abandoned: `busy` falls and no `block_done` is raised.
- R12: With repeat and auto-initialize set under hardware synchronization, every later block waits for a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Effective control word |
| dest_ext | input | 1 | 1: destination is the external display controller |
| dual_block | input | 1 | 1: dual-block mode |
| block_len | input | LEN_W | Beats per block minus one, captured at block start |
| hw_req | input | 1 | Hardware synchronization request, one pulse per request |
| beat_valid | output | 1 | Channel offers an element beat |
| beat_ready | input | 1 | Element beat accepted |
| block_done | output | 1 | One-cycle block completion pulse |
| busy | output | 1 | Block in progress |
| buf_sel | output | 1 | Current buffer in dual-block mode |
| prio_hi | output | 1 | Effective priority bit |
| req_ovf | output | 1 | Dropped-request flag |

## Verification
The assertions take `hw_req` and `reg_wr` to be synchronous single-cycle strobes, and `block_len` to be stable whenever a block may start. The stimulus drives all inputs only on falling edges. It changes `block_len`, `dest_ext` and `dual_block` only while the channel is idle or disabled, and it raises each request as a one-cycle pulse. The assertions also assume nothing about `beat_ready` stalls. The bench therefore holds `beat_ready` low for long stretches to keep a block open while requests arrive or enable is dropped.

// File: rtl/dispch_pkg.sv
package dispch_pkg;
    localparam int REG_W    = 16;
    localparam int B_NATIVE = 10;
    localparam int B_REP    = 9;
    localparam int B_AI     = 8;
    localparam int B_EN     = 7;
    localparam int B_PRI    = 6;
    localparam int B_BS     = 4;

    localparam logic [REG_W-1:0] WR_MASK =
        (1 << B_NATIVE) | (1 << B_REP) | (1 << B_AI) |
        (1 << B_EN) | (1 << B_PRI) | (1 << B_BS);
    localparam logic [REG_W-1:0] FORCE_MASK =
        (1 << B_REP) | (1 << B_AI) | (1 << B_EN) | (1 << B_PRI);

    typedef struct packed {
        logic rep;
        logic ai;
        logic en;
        logic pri;
        logic bs;
    } ctl_t;
endpackage

// File: rtl/dispch_ctrlreg.sv
module dispch_ctrlreg
    import dispch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr_en,
    output ctl_t             eff,
    output logic [REG_W-1:0] rdata
);
    typedef struct packed {
        logic [REG_W-1:0] bits;
    } creg_t;

    creg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            r_d.bits = wdata & WR_MASK;
        end else if (clr_en) begin
            r_d.bits[B_EN] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // legacy mode overlays the forced bits on the stored word
    always_comb begin
        rdata   = r_q.bits | (r_q.bits[B_NATIVE] ? '0 : FORCE_MASK);
        eff.rep = rdata[B_REP];
        eff.ai  = rdata[B_AI];
        eff.en  = rdata[B_EN];
        eff.pri = rdata[B_PRI];
        eff.bs  = rdata[B_BS];
    end
endmodule

// File: rtl/dispch_reqlatch.sv
module dispch_reqlatch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic arm,
    input  logic consume,
    input  logic clr,
    output logic pend,
    output logic ovf
);
    typedef struct packed {
        logic pend;
        logic ovf;
    } rl_t;

    rl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (consume) s_d.pend = 1'b0;
        if (req && arm) begin
            if (s_q.pend && !consume) s_d.ovf  = 1'b1;
            else                      s_d.pend = 1'b1;
        end
        if (clr) begin
            s_d.pend = 1'b0;
            s_d.ovf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
    assign ovf  = s_q.ovf;

    AST_CONSUME_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> s_q.pend); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !clr) |=> s_q.ovf); // R8
endmodule

// File: rtl/dispch_beatctr.sv
module dispch_beatctr #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat,
    input  logic             abort,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } bc_t;

    bc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (start) begin
            c_d.cnt = '0;
            c_d.len = len;
        end else if (abort) begin
            c_d.cnt = '0;
        end else if (beat) begin
            c_d.cnt = last ? '0 : c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign last = (c_q.cnt == c_q.len);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= c_q.len); // R7
endmodule

// File: rtl/dispch_trig.sv
module dispch_trig
    import dispch_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             dest_ext,
    input  logic             dual_block,
    input  logic [LEN_W-1:0] block_len,
    input  logic             hw_req,
    output logic             beat_valid,
    input  logic             beat_ready,
    output logic             block_done,
    output logic             busy,
    output logic             buf_sel,
    output logic             prio_hi,
    output logic             req_ovf
);
    typedef struct packed {
        logic busy;
        logic done;
        logic bsel;
    } tr_t;

    tr_t  t_d, t_q;
    ctl_t eff;
    logic pend, last, clr_en;

    logic need_hw, can_start, acc, abort, fin, consume;

    always_comb begin
        need_hw   = dest_ext & eff.bs;
        can_start = !t_q.busy & eff.en & (!need_hw | pend);
        acc       = t_q.busy & beat_ready;
        abort     = t_q.busy & !eff.en;
        fin       = acc & last & eff.en;
        consume   = can_start & need_hw;
        clr_en    = fin & !(eff.ai & eff.rep) & (!dual_block | t_q.bsel);
    end

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (can_start) begin
            t_d.busy = 1'b1;
        end else if (abort) begin
            t_d.busy = 1'b0;
        end else if (fin) begin
            t_d.busy = 1'b0;
            t_d.done = 1'b1;
            if (dual_block) t_d.bsel = ~t_q.bsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    dispch_ctrlreg u_creg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .clr_en (clr_en),
        .eff    (eff),
        .rdata  (reg_rdata)
    );

    dispch_reqlatch u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (hw_req),
        .arm     (need_hw),
        .consume (consume),
        .clr     (reg_wr),
        .pend    (pend),
        .ovf     (req_ovf)
    );

    dispch_beatctr #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (can_start),
        .beat  (acc & !abort),
        .abort (abort),
        .len   (block_len),
        .last  (last)
    );

    assign beat_valid = t_q.busy;
    assign busy       = t_q.busy;
    assign block_done = t_q.done;
    assign buf_sel    = t_q.bsel;
    assign prio_hi    = eff.pri;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done); // R7
    AST_LEGACY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_NATIVE] |-> (&reg_rdata[B_REP:B_PRI])); // R2
    AST_BUFSEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (block_done && $past(dual_block)) |-> (buf_sel != $past(buf_sel))); // R9
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reg_rdata[B_EN]) |=> (!busy && !block_done)); // R11
endmodule

// File: tb/sim_dispch_trig.sv
`timescale 1ns/1ps
module sim_dispch_trig;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic dest_ext = 1'b0, dual_block = 1'b0, hw_req = 1'b0, beat_ready = 1'b0;
    logic [LEN_W-1:0] block_len = '0;
    logic beat_valid, block_done, busy, buf_sel, prio_hi, req_ovf;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, beats = 0, dones = 0, last_acc = 0, done_cyc = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    dispch_trig #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dest_ext(dest_ext), .dual_block(dual_block),
        .block_len(block_len), .hw_req(hw_req), .beat_valid(beat_valid),
        .beat_ready(beat_ready), .block_done(block_done), .busy(busy),
        .buf_sel(buf_sel), .prio_hi(prio_hi), .req_ovf(req_ovf)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (beat_valid && beat_ready) begin
            beats    <= beats + 1;
            last_acc <= cyc;
        end
        if (block_done) begin
            dones    <= dones + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk); hw_req = 1'b1;
        @(negedge clk); hw_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ctrl, dest_ext, len, use request, expected beats
    typedef struct packed {
        logic [15:0] ctrl;
        logic        dest;
        logic [7:0]  len;
        logic        useq;
        logic [7:0]  nbeat;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{16'h0480, 1'b1, 8'd3, 1'b0, 8'd4},  // R5 software trigger
        '{16'h0490, 1'b1, 8'd0, 1'b1, 8'd1},  // R3 hw sync, one beat
        '{16'h0490, 1'b0, 8'd5, 1'b0, 8'd6},  // R6 bs ignored
        '{16'h0480, 1'b0, 8'd7, 1'b0, 8'd8}   // R7 length
    };

    initial begin
        #500000;
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int b0, d0;
        idle(3);
        chk("R1 reset read", reg_rdata, 16'h03C0);
        chk("R9 reset buf_sel", buf_sel, 0);
        rst_n = 1'b1;
        idle(4);
        chk("R2 legacy busy", busy, 1);
        chk("R2 legacy prio", prio_hi, 1);
        wr(16'h0000);
        chk("R2 legacy read", reg_rdata, 16'h03C0);
        chk("R2 still busy", busy, 1);
        d0 = dones;
        wr(16'h0400);
        idle(2);
        chk("R11 abort busy", busy, 0);
        beat_ready = 1'b1;
        idle(4);
        chk("R11 abort no done", dones - d0, 0);
        wr(16'hFD3F);
        chk("R1 reserved read", reg_rdata, 16'h0510);

        // vector table
        foreach (VECS[i]) begin
            dest_ext  = VECS[i].dest;
            block_len = VECS[i].len;
            b0 = beats; d0 = dones;
            wr(VECS[i].ctrl);
            if (VECS[i].useq) pulse_req();
            for (int k = 0; k < 200 && dones == d0; k++) @(negedge clk);
            idle(4);
            chk("R7 beats", beats - b0, int'(VECS[i].nbeat));
            chk("R7 one done", dones - d0, 1);
            chk("R7 done timing", done_cyc - last_acc, 1);
            chk("R10 enable cleared", reg_rdata[7], 0);
            chk("R9 single no flip", buf_sel, 0);
        end

        // R3: no start without request
        dest_ext = 1'b1; block_len = 8'd2;
        d0 = dones;
        wr(16'h0490);
        idle(10);
        chk("R3 no req no start", busy, 0);
        pulse_req();
        idle(15);
        chk("R3 one req one block", dones - d0, 1);

        // R4 / R9 / R10 dual block
        dual_block = 1'b1; block_len = 8'd1;
        d0 = dones;
        wr(16'h0490);
        pulse_req();
        idle(15);
        chk("R4 first block", dones - d0, 1);
        chk("R4 waits second req", busy, 0);
        chk("R9 flip to 1", buf_sel, 1);
        chk("R10 dual keeps enable", reg_rdata[7], 1);
        pulse_req();
        idle(15);
        chk("R4 second block", dones - d0, 2);
        chk("R9 flip to 0", buf_sel, 0);
        chk("R10 dual clears enable", reg_rdata[7], 0);
        dual_block = 1'b0;

        // R10 auto-init without repeat
        dest_ext = 1'b0; block_len = 8'd2;
        d0 = dones;
        wr(16'h0580);
        idle(20);
        chk("R10 ai only one block", dones - d0, 1);
        chk("R10 ai only clears", reg_rdata[7], 0);
        d0 = dones;
        wr(16'h0780);
        idle(30);
        chk("R10 repeat keeps running", int'(dones - d0 >= 2), 1);
        chk("R10 repeat keeps enable", reg_rdata[7], 1);
        wr(16'h0400);
        idle(12);

        // R11 native abort
        beat_ready = 1'b0; block_len = 8'd7;
        d0 = dones;
        wr(16'h0480);
        idle(3);
        chk("R11 started", busy, 1);
        wr(16'h0400);
        idle(3);
        chk("R11 native abort", busy, 0);
        beat_ready = 1'b1;
        idle(5);
        chk("R11 no done", dones - d0, 0);

        // R8 / R12
        beat_ready = 1'b0; dest_ext = 1'b1;
        d0 = dones;
        wr(16'h0790);
        idle(5);
        chk("R12 waits first req", busy, 0);
        pulse_req();
        idle(3);
        chk("R8 active", busy, 1);
        chk("R8 no ovf yet", req_ovf, 0);
        pulse_req();
        pulse_req();
        idle(1);
        chk("R8 overflow set", req_ovf, 1);
        beat_ready = 1'b1;
        idle(40);
        chk("R8 pending served", dones - d0, 2);
        chk("R12 idle without req", busy, 0);
        chk("R8 ovf sticky", req_ovf, 1);
        pulse_req();
        idle(15);
        chk("R12 new req new block", dones - d0, 3);
        wr(16'h0790);
        chk("R8 ovf cleared", req_ovf, 0);

        ended = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule